// File: doc/BRIEF.md
# Tearing-Effect Sync Detector

The block watches the tearing-effect output of a display panel. Line sync and frame sync arrive on the same pin and differ only in pulse width. A frame sync (vsync) is always wider than a line sync (hsync) and is at least eight ticks long. The block brings the pin into its own clock domain and measures how long each pulse stays active. It counts in ticks of a clock enable that divides the core clock by 1 to 8. When a pulse ends, the block classifies it as vsync, hsync or noise, and each sync type has its own polarity inversion.

After a vsync the block counts the hsync pulses that follow. It raises a one-cycle `match_o` pulse at the programmed trigger point: on the vsync itself, or on a chosen hsync after it. The system uses the falling edge of that pulse to release a frame transfer that has been held. All configuration comes in on parallel inputs and is expected to stay stable while the panel is running.

Top module: `te_sync_detect`

## Requirements
- R1: After `rst_ni` is released, `match_o` is low, and no match occurs in line mode until a vsync has been seen.
- R2: A pulse whose active width is at least (`vs_width_i`+1)*8 ticks is classified as a vsync.
- R3: A pulse at least `hs_width_i`+1 ticks wide but narrower than the vsync threshold is classified as an hsync. A narrower pulse is ignored and does not advance the line count.
- R4: `mode_i`=3 (frame mode) produces one match for every vsync.
- R5: `mode_i`=2 (line mode) produces a match on the hsync that brings the count after the last vsync up to `line_i`. With `line_i`=0, line mode never matches.
- R6: In line mode there is at most one match per frame, and every vsync clears the line count back to zero.
- R7: `mode_i`=0 and the reserved value 1 produce no match, whatever pulses arrive.
- R8: With the polarity bit for a sync type cleared, that type's active level on `te_i` is high. With the bit set, the active level is low.
- R9: A tick occurs every `div_i`+1 core clocks, and pulse widths are counted in ticks.
- R10: `match_o` is high for exactly one clock. It rises on the fourth rising clock edge after the edge of `te_i` that ends the deciding pulse.
- R11: Active widths of up to 4096 ticks are measured without wrapping, so the widest vsync threshold is still reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| te_i | input | 1 | Tearing-effect pin from the panel, asynchronous |
| mode_i | input | 2 | 0/1 off, 2 line mode, 3 frame mode |
| div_i | input | 3 | Tick divider minus one |
| vs_width_i | input | 9 | Vsync threshold in units of 8 ticks, minus one |
| hs_width_i | input | 3 | Hsync threshold in ticks, minus one |
| vs_inv_i | input | 1 | Vsync active low when set |
| hs_inv_i | input | 1 | Hsync active low when set |
| line_i | input | 11 | Trigger line count in line mode |
| match_o | output | 1 | One-cycle trigger pulse |

## Verification
On every cycle, the assertions check the following: the tick spacing, that the width counters never go backwards except when they clear, that end-of-pulse strobes and matches last one cycle, that every vsync clears the line count, and that a match is only ever caused by an enabled mode and an event of the matching kind. Only the bench scenarios can show the rest. They sweep pulse widths across both thresholds to show where classification flips. They step the trigger line to show which hsync fires. They also cover one match per frame, the inverted polarity, divided ticks, the exact latency and the 4096-tick saturation case.

// File: rtl/te_pkg.sv
package te_pkg;
  localparam int unsigned CNT_W  = 13;
  localparam int unsigned LINE_W = 11;
  localparam int unsigned VSF_W  = 9;
  localparam int unsigned HSF_W  = 3;
  localparam int unsigned DIV_W  = 3;

  typedef enum logic [1:0] {
    TE_OFF   = 2'd0,
    TE_RSVD  = 2'd1,
    TE_LINE  = 2'd2,
    TE_FRAME = 2'd3
  } te_mode_e;
endpackage

// File: rtl/te_tick_gen.sv
module te_tick_gen #(
  parameter int unsigned DIV_W = te_pkg::DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q >= div_i) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == '0);

  // R9: ticks spaced by div+1 clocks
  a_r9_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> (!tick_o || !$stable(div_i)));
endmodule

// File: rtl/te_width_meas.sv
module te_width_meas #(
  parameter int unsigned CNT_W = te_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             lvl_i,
  output logic             done_o,
  output logic [CNT_W-1:0] width_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             end_w;

  assign end_w = lvl_q && !lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= 1'b0;
      cnt_q   <= '0;
      done_o  <= 1'b0;
      width_o <= '0;
    end else begin
      lvl_q  <= lvl_i;
      done_o <= end_w;
      if (end_w) begin
        width_o <= cnt_q;
        cnt_q   <= '0;
      end else if (lvl_i && tick_i && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R11: counter only grows or clears, never wraps
  a_r11_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> (cnt_q == '0 || cnt_q >= $past(cnt_q)));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/te_line_match.sv
module te_line_match
  import te_pkg::*;
#(
  parameter int unsigned CNT_W  = te_pkg::CNT_W,
  parameter int unsigned LINE_W = te_pkg::LINE_W,
  parameter int unsigned VSF_W  = te_pkg::VSF_W,
  parameter int unsigned HSF_W  = te_pkg::HSF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [VSF_W-1:0]  vs_width_i,
  input  logic [HSF_W-1:0]  hs_width_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              vs_done_i,
  input  logic [CNT_W-1:0]  vs_len_i,
  input  logic              hs_done_i,
  input  logic [CNT_W-1:0]  hs_len_i,
  output logic              match_o
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [CNT_W-1:0]  vs_thr, hs_thr;
  logic              vs_evt, hs_evt;
  logic [LINE_W-1:0] line_q, line_nxt;
  logic              armed_q;

  // thresholds: (vs+1)*8 ticks, hs+1 ticks
  assign vs_thr = CNT_W'({1'b0, vs_width_i} + 1'b1) << 3;
  assign hs_thr = CNT_W'(hs_width_i) + 1'b1;

  assign vs_evt   = vs_done_i && (vs_len_i >= vs_thr);
  assign hs_evt   = hs_done_i && (hs_len_i >= hs_thr) && (hs_len_i < vs_thr);
  assign line_nxt = (line_q == LINE_MAX) ? line_q : line_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      armed_q <= 1'b0;
      match_o <= 1'b0;
    end else begin
      match_o <= 1'b0;
      if (vs_evt) begin
        line_q  <= '0;
        armed_q <= 1'b1;
        match_o <= (mode_i == TE_FRAME);
      end else if (hs_evt && armed_q) begin
        line_q <= line_nxt;
        if (mode_i == TE_LINE && line_i != '0 && line_nxt == line_i) begin
          match_o <= 1'b1;
          armed_q <= 1'b0;
        end
      end
    end
  end

  a_r6_vsync_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_evt |=> (line_q == '0 && armed_q));

  a_r7_mode_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> ($past(mode_i) == TE_LINE || $past(mode_i) == TE_FRAME));

  a_r4_frame_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && $past(mode_i) == TE_FRAME) |-> $past(vs_done_i));

  a_r5_line_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && $past(mode_i) == TE_LINE) |-> $past(hs_done_i));

  a_r10_match_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);
endmodule

// File: rtl/te_sync_detect.sv
module te_sync_detect
  import te_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              te_i,
  input  logic [1:0]        mode_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [VSF_W-1:0]  vs_width_i,
  input  logic [HSF_W-1:0]  hs_width_i,
  input  logic              vs_inv_i,
  input  logic              hs_inv_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              match_o
);
  localparam int unsigned NSYNC = 2; // index 0: vsync view, 1: hsync view

  logic [1:0]       sync_q;
  logic             tick;
  logic [NSYNC-1:0] lvl, done;
  logic [CNT_W-1:0] len [NSYNC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], te_i};
  end

  assign lvl[0] = sync_q[1] ^ vs_inv_i;
  assign lvl[1] = sync_q[1] ^ hs_inv_i;

  te_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_i),
    .tick_o (tick)
  );

  for (genvar g = 0; g < NSYNC; g++) begin : g_meas
    te_width_meas #(.CNT_W(CNT_W)) u_meas (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .lvl_i   (lvl[g]),
      .done_o  (done[g]),
      .width_o (len[g])
    );
  end

  te_line_match #(
    .CNT_W(CNT_W), .LINE_W(LINE_W), .VSF_W(VSF_W), .HSF_W(HSF_W)
  ) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .vs_width_i (vs_width_i),
    .hs_width_i (hs_width_i),
    .line_i     (line_i),
    .vs_done_i  (done[0]),
    .vs_len_i   (len[0]),
    .hs_done_i  (done[1]),
    .hs_len_i   (len[1]),
    .match_o    (match_o)
  );
endmodule

// File: tb/te_sync_detect_tb.sv
`timescale 1ns/1ps
module te_sync_detect_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        te = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [2:0]  div = 3'd0;
  logic [8:0]  vsw = 9'd1;
  logic [2:0]  hsw = 3'd2;
  logic        vinv = 1'b0, hinv = 1'b0;
  logic [10:0] line = 11'd0;
  logic        match_o;
  logic        idle = 1'b0;
  int n_chk = 0, n_err = 0, mcnt = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  te_sync_detect u_dut (
    .clk_i(clk), .rst_ni(rst_n), .te_i(te), .mode_i(mode), .div_i(div),
    .vs_width_i(vsw), .hs_width_i(hsw), .vs_inv_i(vinv), .hs_inv_i(hinv),
    .line_i(line), .match_o(match_o)
  );

  always @(posedge clk) if (rst_n && match_o) mcnt++;

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic pulse(int w);
    @(negedge clk); te = ~idle;
    repeat (w) @(negedge clk);
    te = idle;
    repeat (8) @(negedge clk);
  endtask

  task automatic reset_dut();
    @(negedge clk); rst_n = 1'b0; te = idle;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mcnt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int exp;
    reset_dut();
    // R1 reset state and no line match before a vsync
    chk("R1 match_o after reset", int'(match_o), 0);
    mode = 2'd2; line = 11'd1;
    pulse(4); pulse(4);
    chk("R1 no line match before vsync", mcnt, 0);

    // R2/R4 width sweep in frame mode, vs threshold 16 ticks
    mode = 2'd3; vsw = 9'd1; hsw = 3'd2;
    for (int w = 1; w <= 24; w++) begin
      mcnt = 0;
      pulse(w);
      chk($sformatf("R2 R4 width %0d", w), mcnt, (w >= 16) ? 1 : 0);
    end

    // R5 trigger line sweep
    mode = 2'd2;
    for (int l = 1; l <= 5; l++) begin
      line = 11'(l);
      mcnt = 0;
      pulse(20);
      for (int k = 1; k <= 6; k++) begin
        pulse(4);
        chk($sformatf("R5 R6 line %0d hsync %0d", l, k), mcnt, (k >= l) ? 1 : 0);
      end
    end

    // R5 line 0 never matches in line mode
    line = 11'd0; mcnt = 0;
    pulse(20); pulse(4); pulse(4);
    chk("R5 line 0", mcnt, 0);

    // R3 short pulses ignored, threshold 3 ticks
    line = 11'd2; mcnt = 0;
    pulse(20); pulse(2); pulse(2); pulse(1);
    chk("R3 short pulses ignored", mcnt, 0);
    pulse(3);
    chk("R3 first hsync at threshold", mcnt, 0);
    pulse(3);
    chk("R3 second hsync", mcnt, 1);

    // R3 width just under vsync threshold is an hsync
    mcnt = 0;
    pulse(20); pulse(15);
    chk("R3 width 15 counts as line", mcnt, 0);
    pulse(15);
    chk("R3 width 15 second line", mcnt, 1);

    // R6 vsync clears count
    mcnt = 0;
    pulse(20); pulse(4); pulse(16); pulse(4);
    chk("R6 vsync clears line count", mcnt, 0);
    pulse(4);
    chk("R6 match after recount", mcnt, 1);

    // R7 off and reserved modes
    for (int m = 0; m <= 1; m++) begin
      mode = 2'(m); line = 11'd1; mcnt = 0;
      pulse(20); pulse(4); pulse(4); pulse(30);
      chk($sformatf("R7 mode %0d silent", m), mcnt, 0);
    end

    // R8 inverted polarity, idle high
    mode = 2'd3; vinv = 1'b1; hinv = 1'b1; idle = 1'b1;
    reset_dut();
    pulse(20);
    chk("R8 inverted vsync", mcnt, 1);
    mode = 2'd2; line = 11'd1; mcnt = 0;
    pulse(20); pulse(4);
    chk("R8 inverted hsync", mcnt, 1);
    vinv = 1'b0; hinv = 1'b0; idle = 1'b0;
    reset_dut();

    // R9 divided ticks: div 4, threshold 16 ticks = 64 clocks
    mode = 2'd3; div = 3'd3; mcnt = 0;
    pulse(56);
    chk("R9 14 ticks not vsync", mcnt, 0);
    pulse(72);
    chk("R9 18 ticks vsync", mcnt, 1);
    div = 3'd0;

    // R10 latency and single-cycle width
    mcnt = 0;
    @(negedge clk); te = 1'b1;
    repeat (20) @(negedge clk);
    te = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R10 low before 4th edge", int'(match_o), 0);
    @(posedge clk);
    #1 chk("R10 high after 4th edge", int'(match_o), 1);
    @(posedge clk);
    #1 chk("R10 one cycle", int'(match_o), 0);
    repeat (4) @(negedge clk);

    // R11 widest threshold 4096 ticks
    vsw = 9'd511; mcnt = 0;
    pulse(4090);
    chk("R11 4090 below threshold", mcnt, 0);
    pulse(4100);
    chk("R11 4100 reaches threshold", mcnt, 1);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule